// File: doc/BRIEF.md
# Interrupt Controller Indirect Register File

This block is the software-visible register store of an I/O interrupt controller with a parameterised number of input pins (24 by default). Software reaches it through two memory-mapped locations: a select register that holds an 8-bit register index, and a 32-bit data window that reads or writes whichever internal register the select value currently names. Behind the window are a read-only version register, a writable 4-bit controller ID (with a read-only arbitration alias), and one 64-bit routing entry per pin, each reached as a low and a high 32-bit word.

Each routing entry carries two status bits that software cannot write: remote IRR and delivery status. These bits are exported to, and changed by, the neighbouring trigger and end-of-interrupt logic through set and clear strobes. When software rewrites an entry so that it becomes a level-triggered, unmasked entry with remote IRR clear while its pin is asserted, the block sets remote IRR itself and pulses a one-cycle delivery request for that pin, so a pending level interrupt is not lost across reprogramming.

Top module: `ioint_regfile`

## Requirements
- R1: Only bus address bits 7:0 are decoded. Offset 0x00 is the select register (8 bits, reads back exactly as written in rd_data[7:0], upper bits zero); offset 0x10 is the data window; any other offset reads zero and a write there changes nothing.
- R2: Select value 0x01 names the version register, which reads {8'h00, NUM_PINS-1, 8'h00, 8'h11} (pin count minus one in bits 23:16, version code 0x11 in bits 7:0); writes to it are ignored.
- R3: Select value 0x00 names the ID register: a write stores wdata[27:24] and a read returns it in bits 27:24 with all other bits zero. Select value 0x02 reads the same value and ignores writes.
- R4: Select value 0x10 + 2*i names the low word (bits 31:0) of entry i and 0x11 + 2*i names its high word (bits 63:32).
- R5: A select value from 0x10 upward whose entry index (select-0x10)>>1 is at or beyond NUM_PINS reads zero, and a write through it changes no entry; select values 0x03 to 0x0F also read zero.
- R6: A high-word write replaces entry bits 63:32 only and leaves bits 31:0 unchanged.
- R7: A low-word write replaces bits 31:0 except that delivery status (bit 12) becomes 0 and remote IRR (bit 14) keeps its value.
- R8: After a write to entry i, if bit 15 (trigger, 1 = level) is 1, bit 16 (mask) is 0, remote IRR is 0 and pin_level[i] is 1, remote IRR of entry i becomes 1 and deliver_req[i] is high for exactly the one cycle after the write; otherwise no request is raised.
- R9: irr_set[i]/irr_clr[i] set/clear remote IRR of entry i and ds_set[i]/ds_clr[i] set/clear its delivery status, one cycle later, set winning over clear; remote_irr_o, mask_o and level_o export bits 14, 16 and 15 of every entry.
- R10: After reset the select and ID registers are zero and every entry reads 0x0000_0000_0001_0000 (only the mask bit set), with deliver_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address; only bits 7:0 decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for bus_addr, combinational |
| pin_level | input | NUM_PINS | Current asserted state of each pin |
| irr_set | input | NUM_PINS | Set remote IRR per entry |
| irr_clr | input | NUM_PINS | Clear remote IRR per entry |
| ds_set | input | NUM_PINS | Set delivery status per entry |
| ds_clr | input | NUM_PINS | Clear delivery status per entry |
| remote_irr_o | output | NUM_PINS | Remote IRR bit of each entry |
| mask_o | output | NUM_PINS | Mask bit of each entry |
| level_o | output | NUM_PINS | Trigger-mode bit of each entry |
| deliver_req | output | NUM_PINS | One-cycle delivery request per pin |

## Verification
A wrong select value or a wrong index computation shows up at rd_data as soon as the window is read in the same cycle, because the read path is combinational from the registered select. A corrupted status bit appears on remote_irr_o one cycle after the offending write or strobe, and a missed or spurious delivery request is visible on deliver_req in the cycle right after the write that should or should not have raised it. The directed scenarios therefore read back each word just after writing it and sample the request and exported status bits exactly one cycle after each write.

// File: rtl/ioint_pkg.sv
package ioint_pkg;

    // Bit positions inside a 64-bit routing entry
    localparam int B_DS   = 12;
    localparam int B_IRR  = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

    // Select values of the fixed registers
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_ENT0 = 8'h10;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENT,
        K_NONE
    } target_e;

    typedef struct packed {
        logic [63:0] ent;
        logic        req;
    } ent_state_t;

    typedef struct packed {
        logic [7:0] sel;
        logic [3:0] id;
    } top_state_t;

endpackage

// File: rtl/ioint_decode.sv
module ioint_decode
    import ioint_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter logic [7:0] OFS_SEL = 8'h00,
    parameter logic [7:0] OFS_WIN = 8'h10,
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [7:0]       addr_lo,
    input  logic [7:0]       sel_q,
    output logic             hit_sel,
    output logic             hit_win,
    output target_e          kind,
    output logic [IDX_W-1:0] ent_idx,
    output logic             ent_hi
);

    logic [7:0] raw_idx;

    always_comb begin
        hit_sel = (addr_lo == OFS_SEL);
        hit_win = (addr_lo == OFS_WIN);
        raw_idx = (sel_q - SEL_ENT0) >> 1;
        ent_idx = raw_idx[IDX_W-1:0];
        ent_hi  = sel_q[0];
        if (sel_q == SEL_ID) begin
            kind = K_ID;
        end else if (sel_q == SEL_VER) begin
            kind = K_VER;
        end else if (sel_q == SEL_ARB) begin
            kind = K_ARB;
        end else if (sel_q >= SEL_ENT0 && 32'(raw_idx) < NUM_PINS) begin
            kind = K_ENT;
        end else begin
            kind = K_NONE;
        end
    end

endmodule

// File: rtl/ioint_entry.sv
module ioint_entry
    import ioint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        pin_level,
    input  logic        irr_set,
    input  logic        irr_clr,
    input  logic        ds_set,
    input  logic        ds_clr,
    output logic [63:0] ent_o,
    output logic        req_o
);

    localparam logic [63:0] ENT_RST = 64'(1) << B_MASK;

    ent_state_t q, d;
    logic       keep_irr;

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        keep_irr = 1'b0;
        // status strobes from trigger / end-of-interrupt logic
        if (irr_clr) d.ent[B_IRR] = 1'b0;
        if (irr_set) d.ent[B_IRR] = 1'b1;
        if (ds_clr)  d.ent[B_DS]  = 1'b0;
        if (ds_set)  d.ent[B_DS]  = 1'b1;
        // software writes
        if (wr_hi) d.ent[63:32] = wdata;
        if (wr_lo) begin
            keep_irr        = d.ent[B_IRR];
            d.ent[31:0]     = wdata;
            d.ent[B_DS]     = 1'b0;
            d.ent[B_IRR]    = keep_irr;
        end
        // a reprogrammed level entry with its pin still high asks again
        if ((wr_lo || wr_hi) && d.ent[B_TRIG] && !d.ent[B_MASK] &&
            !d.ent[B_IRR] && pin_level) begin
            d.ent[B_IRR] = 1'b1;
            d.req        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ent <= ENT_RST;
            q.req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ent_o = q.ent;
    assign req_o = q.req;

endmodule

// File: rtl/ioint_rdmux.sv
module ioint_rdmux
    import ioint_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  logic        hit_sel,
    input  logic        hit_win,
    input  target_e     kind,
    input  logic        ent_hi,
    input  logic [7:0]  sel_q,
    input  logic [3:0]  id_q,
    input  logic [63:0] ent_word,
    output logic [31:0] rd_data
);

    localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

    logic [31:0] win_data;

    always_comb begin
        unique case (kind)
            K_VER:   win_data = {8'h00, MAX_PIN, 8'h00, VER_CODE};
            K_ID,
            K_ARB:   win_data = {4'h0, id_q, 24'h0};
            K_ENT:   win_data = ent_hi ? ent_word[63:32] : ent_word[31:0];
            default: win_data = 32'h0;
        endcase
        if (hit_sel)      rd_data = {24'h0, sel_q};
        else if (hit_win) rd_data = win_data;
        else              rd_data = 32'h0;
    end

endmodule

// File: rtl/ioint_regfile.sv
module ioint_regfile
    import ioint_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W = 32,
    parameter logic [7:0] VER_CODE = 8'h11,
    parameter logic [7:0] OFS_SEL = 8'h00,
    parameter logic [7:0] OFS_WIN = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         rd_data,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] irr_set,
    input  logic [NUM_PINS-1:0] irr_clr,
    input  logic [NUM_PINS-1:0] ds_set,
    input  logic [NUM_PINS-1:0] ds_clr,
    output logic [NUM_PINS-1:0] remote_irr_o,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] level_o,
    output logic [NUM_PINS-1:0] deliver_req
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    top_state_t       q, d;
    logic             hit_sel, hit_win, ent_hi;
    target_e          kind;
    logic [IDX_W-1:0] ent_idx;
    logic [63:0]      ent_all [NUM_PINS];
    logic [63:0]      ent_cur;
    logic             win_wr;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

    ioint_decode #(
        .NUM_PINS (NUM_PINS),
        .OFS_SEL  (OFS_SEL),
        .OFS_WIN  (OFS_WIN)
    ) dec_i (
        .addr_lo (bus_addr[7:0]),
        .sel_q   (q.sel),
        .hit_sel (hit_sel),
        .hit_win (hit_win),
        .kind    (kind),
        .ent_idx (ent_idx),
        .ent_hi  (ent_hi)
    );

    assign win_wr = bus_wr && hit_win;

    always_comb begin
        d = q;
        if (bus_wr && hit_sel)          d.sel = bus_wdata[7:0];
        if (win_wr && kind == K_ID)     d.id  = bus_wdata[27:24];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_ent
        logic hit_i;
        assign hit_i = win_wr && (kind == K_ENT) && (32'(ent_idx) == gi);

        ioint_entry ent_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit_i && !ent_hi),
            .wr_hi     (hit_i && ent_hi),
            .wdata     (bus_wdata),
            .pin_level (pin_level[gi]),
            .irr_set   (irr_set[gi]),
            .irr_clr   (irr_clr[gi]),
            .ds_set    (ds_set[gi]),
            .ds_clr    (ds_clr[gi]),
            .ent_o     (ent_all[gi]),
            .req_o     (deliver_req[gi])
        );

        assign remote_irr_o[gi] = ent_all[gi][B_IRR];
        assign mask_o[gi]       = ent_all[gi][B_MASK];
        assign level_o[gi]      = ent_all[gi][B_TRIG];
    end

    always_comb begin
        ent_cur = 64'h0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (32'(ent_idx) == i) ent_cur = ent_all[i];
        end
    end

    ioint_rdmux #(
        .NUM_PINS (NUM_PINS),
        .VER_CODE (VER_CODE)
    ) mux_i (
        .hit_sel  (hit_sel),
        .hit_win  (hit_win),
        .kind     (kind),
        .ent_hi   (ent_hi),
        .sel_q    (q.sel),
        .id_q     (q.id),
        .ent_word (ent_cur),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/ioint_regfile_chk.sv
module ioint_regfile_chk #(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W = 32,
    parameter logic [7:0] OFS_SEL = 8'h00,
    parameter logic [7:0] OFS_WIN = 8'h10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [31:0]         rd_data,
    input logic [NUM_PINS-1:0] irr_set,
    input logic [NUM_PINS-1:0] irr_clr,
    input logic [NUM_PINS-1:0] remote_irr_o,
    input logic [NUM_PINS-1:0] deliver_req
);

    // R8: a delivery request always comes with remote IRR set
    a_r8_req_has_irr: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_req & ~remote_irr_o) == '0);

    // R8: a request only follows a bus write
    a_r8_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_req != '0) |-> $past(bus_wr));

    // R8: one write can touch one entry, so at most one request
    a_r8_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deliver_req));

    // R9: a set strobe shows on the exported bit one cycle later
    a_r9_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_set != '0) |=> (($past(irr_set) & ~remote_irr_o) == '0));

    // R9: a clear strobe without set and without a bus write clears the bit
    a_r9_clr_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_clr != '0 && irr_set == '0 && !bus_wr) |=>
        (($past(irr_clr) & remote_irr_o) == '0));

    // R1: select read returns only eight significant bits
    a_r1_sel_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[7:0] == OFS_SEL) |-> (rd_data[31:8] == 24'h0));

    // R1: undecoded offsets read zero
    a_r1_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[7:0] != OFS_SEL && bus_addr[7:0] != OFS_WIN) |-> (rd_data == 32'h0));

endmodule

bind ioint_regfile ioint_regfile_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .OFS_SEL  (OFS_SEL),
    .OFS_WIN  (OFS_WIN)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .rd_data      (rd_data),
    .irr_set      (irr_set),
    .irr_clr      (irr_clr),
    .remote_irr_o (remote_irr_o),
    .deliver_req  (deliver_req)
);

// File: tb/ioint_regfile_tb_top.sv
module ioint_regfile_tb_top;

    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  pin_level = '0;
    logic [N-1:0]  irr_set = '0, irr_clr = '0, ds_set = '0, ds_clr = '0;
    logic [N-1:0]  remote_irr_o, mask_o, level_o, deliver_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ioint_regfile #(.NUM_PINS(N), .ADDR_W(32)) dut_i (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .rd_data,
        .pin_level, .irr_set, .irr_clr, .ds_set, .ds_clr,
        .remote_irr_o, .mask_o, .level_o, .deliver_req
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bwr(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [31:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic win_wr(input logic [7:0] s, input logic [31:0] v);
        bwr(32'h0, {24'h0, s});
        bwr(32'h10, v);
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] v);
        bwr(32'h0, {24'h0, s});
        brd(32'h10, v);
    endtask

    task automatic strobe(input int pin, input bit iset, input bit iclr, input bit dset, input bit dclr);
        @(negedge clk);
        irr_set[pin] = iset; irr_clr[pin] = iclr; ds_set[pin] = dset; ds_clr[pin] = dclr;
        @(negedge clk);
        irr_set = '0; irr_clr = '0; ds_set = '0; ds_clr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        brd(32'h0, v);
        check("R10 select after reset", v, 0);
        win_rd(8'h00, v);
        check("R10 id after reset", v, 0);
        check("R10 mask_o all set", mask_o, {N{1'b1}});
        check("R10 remote_irr_o clear", remote_irr_o, 0);
        check("R10 deliver_req low", deliver_req, 0);
        for (int i = 0; i < N; i++) begin
            win_rd(8'(8'h10 + 2 * i), v);
            check($sformatf("R10 entry %0d low", i), v, 32'h0001_0000);
            win_rd(8'(8'h11 + 2 * i), v);
            check($sformatf("R10 entry %0d high", i), v, 0);
        end
    endtask

    task automatic t_decode();
        logic [31:0] v;
        bwr(32'h0, 32'hFFFF_FF5A);
        brd(32'h0, v);
        check("R1 select readback 8 bits", v, 32'h5A);
        brd(32'hABCD_0100, v);
        check("R1 alias high address bits", v, 32'h5A);
        brd(32'h4, v);
        check("R1 undecoded offset reads zero", v, 0);
        bwr(32'h20, 32'h77);
        brd(32'h0, v);
        check("R1 write to other offset ignored", v, 32'h5A);
        bwr(32'h1234_5600, 32'h01);
        brd(32'h0, v);
        check("R1 aliased select write", v, 32'h01);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        win_rd(8'h01, v);
        check("R2 version value", v, 32'h0017_0011);
        bwr(32'h10, 32'hFFFF_FFFF);
        brd(32'h10, v);
        check("R2 version write ignored", v, 32'h0017_0011);
        win_wr(8'h00, 32'hA5FF_FFFF);
        brd(32'h10, v);
        check("R3 id stores bits 27:24", v, 32'h0500_0000);
        win_rd(8'h02, v);
        check("R3 arbitration alias", v, 32'h0500_0000);
        bwr(32'h10, 32'h0C00_0000);
        win_rd(8'h00, v);
        check("R3 arbitration write ignored", v, 32'h0500_0000);
        win_rd(8'h05, v);
        check("R5 reserved select reads zero", v, 0);
    endtask

    task automatic t_entries();
        logic [31:0] v;
        win_wr(8'h1A, 32'h0000_5A31);
        brd(32'h10, v);
        check("R7 low write clears ds, keeps irr", v, 32'h0000_0A31);
        check("R4 mask_o pin 5 cleared", mask_o[5], 0);
        win_wr(8'h1B, 32'hC300_0000);
        brd(32'h10, v);
        check("R6 high word readback", v, 32'hC300_0000);
        win_rd(8'h1A, v);
        check("R6 low word kept", v, 32'h0000_0A31);
        win_wr(8'h3F, 32'h1100_0000);
        win_rd(8'h3E, v);
        check("R4 last entry low untouched", v, 32'h0001_0000);
        win_rd(8'h3F, v);
        check("R4 last entry high", v, 32'h1100_0000);
        win_wr(8'h40, 32'h0000_00FF);
        brd(32'h10, v);
        check("R5 out of range reads zero", v, 0);
        win_wr(8'h41, 32'hFF00_0000);
        brd(32'h10, v);
        check("R5 out of range high reads zero", v, 0);
        win_rd(8'h3E, v);
        check("R5 entry 23 unchanged", v, 32'h0001_0000);
        win_rd(8'h3F, v);
        check("R5 entry 23 high unchanged", v, 32'h1100_0000);
    endtask

    task automatic t_status();
        logic [31:0] v;
        strobe(3, 1, 0, 1, 0);
        check("R9 remote_irr_o pin 3 set", remote_irr_o[3], 1);
        win_rd(8'h16, v);
        check("R9 both status bits set", v, 32'h0001_5000);
        win_wr(8'h16, 32'h0000_0022);
        brd(32'h10, v);
        check("R7 irr kept, ds cleared", v, 32'h0000_4022);
        strobe(3, 1, 1, 0, 0);
        check("R9 set wins over clear", remote_irr_o[3], 1);
        strobe(3, 0, 1, 0, 0);
        check("R9 clear", remote_irr_o[3], 0);
        win_wr(8'h16, 32'h0000_8022);
        check("R9 level_o pin 3", level_o[3], 1);
    endtask

    task automatic t_deliver();
        pin_level[7] = 1'b1;
        win_wr(8'h1E, 32'h0000_8040);
        check("R8 request raised", deliver_req, 24'h000080);
        check("R8 irr set by write", remote_irr_o[7], 1);
        @(negedge clk);
        check("R8 request one cycle", deliver_req, 0);
        win_wr(8'h1E, 32'h0000_8041);
        check("R8 no request with irr set", deliver_req, 0);
        strobe(7, 0, 1, 0, 0);
        win_wr(8'h1E, 32'h0001_8041);
        check("R8 no request when masked", deliver_req, 0);
        win_wr(8'h1E, 32'h0000_0041);
        check("R8 no request edge mode", deliver_req, 0);
        pin_level[7] = 1'b0;
        win_wr(8'h1E, 32'h0000_8041);
        check("R8 no request pin low", deliver_req, 0);
        check("R8 irr stays clear", remote_irr_o[7], 0);
        pin_level[7] = 1'b1;
        win_wr(8'h1F, 32'h0200_0000);
        check("R8 high write also requests", deliver_req, 24'h000080);
        pin_level = '0;
    endtask

    task automatic t_rereset();
        logic [31:0] v;
        do_reset();
        check("R10 mask_o after second reset", mask_o, {N{1'b1}});
        win_rd(8'h1E, v);
        check("R10 entry 7 low after reset", v, 32'h0001_0000);
        win_rd(8'h1F, v);
        check("R10 entry 7 high after reset", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_fixed();
        t_entries();
        t_status();
        t_deliver();
        t_rereset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule